// File: doc/BRIEF.md
# Lock-Aware Replacement Slot Selector

This block decides which slot of a fully associative translation buffer receives a new entry. Each cycle it looks at a per-slot valid vector, a per-slot locked vector, and an optional caller-supplied slot number. From these it produces a victim slot number combinationally, so a fill can use it in the same cycle as its insert strobe.

A forced slot number always wins. Otherwise an empty slot is taken before any occupied one. When every slot is occupied, a round-robin search starts one slot past a registered last-replaced pointer. It steps forward with wrap-around, skips locked slots, and never lands back on the pointer's own slot. If that search finds nothing, the highest-numbered slot is used as a fallback.

The pointer advances only when an insert is served by a successful round-robin search. The tag and data arrays, lookup and entry format belong to the surrounding buffer.

Top module: `tlb_victim_sel`

## Requirements
- R1: When `force_en_i` is 1, `victim_idx_o` equals `force_idx_i`, and an insert in that cycle leaves `last_ptr_o` unchanged.
- R2: When nothing is forced and at least one slot has its valid bit at 0, the victim is a slot whose valid bit is 0, whatever the locked bits are.
- R3: Among several slots with valid bit 0, the lowest-numbered one is chosen.
- R4: When all slots are valid and nothing is forced, candidates are visited in the order pointer+1, pointer+2, and so on, wrapping from slot N_SLOTS-1 to slot 0. The first eligible candidate is the victim.
- R5: A slot whose locked bit is 1 is never chosen by the round-robin search.
- R6: The slot held in the last-replaced pointer is not eligible for the search, even when it is unlocked.
- R7: When no eligible slot exists, the victim is slot N_SLOTS-1, and an insert in that cycle leaves `last_ptr_o` unchanged.
- R8: `last_ptr_o` takes the victim's value on the clock edge after an insert served by a successful search. It keeps its value when there is no insert, and when the insert uses a free or forced slot.
- R9: A synchronous reset (`rst_i` high at a clock edge) sets `last_ptr_o` to N_SLOTS-1, so that the first search begins at slot 0.
- R10: `victim_idx_o` depends combinationally on the inputs and the current pointer, with no register in between, so it is valid in the same cycle as the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| insert_i | input | 1 | Insert strobe; lets the pointer advance |
| slot_valid_i | input | N_SLOTS | Per-slot occupied flag (1 = holds an entry) |
| slot_locked_i | input | N_SLOTS | Per-slot locked flag (1 = must not be replaced by search) |
| force_en_i | input | 1 | Use force_idx_i as the victim |
| force_idx_i | input | IDX_W | Caller-supplied slot number (must be below N_SLOTS) |
| victim_idx_o | output | IDX_W | Chosen slot number |
| last_ptr_o | output | IDX_W | Registered last-replaced pointer |

## Verification
Some properties are checked on every cycle. A forced number is passed through unchanged. A free slot wins, and it is the lowest free one. A search result is never a locked slot unless it is the fallback. The pointer holds after forced, free, fallback and idle cycles, and it follows the victim after a successful search. Other behaviour only shows in the bench's directed scenarios, checked against its behavioural model: the exact visiting order starting one past the pointer, the wrap from the top slot to slot 0, and the exclusion of the pointer's own unlocked slot, which forces the fallback.

// File: rtl/tvs_pkg.sv
package tvs_pkg;
   // Which rule produced the victim this cycle.
   typedef enum logic [1:0] {
      PICK_FORCE    = 2'd0,
      PICK_FREE     = 2'd1,
      PICK_SCAN     = 2'd2,
      PICK_FALLBACK = 2'd3
   } pick_src_e;
endpackage

// File: rtl/tvs_lowest_set.sv
// Priority encoder: position of the lowest set bit.
module tvs_lowest_set #(
   parameter  int W  = 16,
   localparam int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  vec_i,
   output logic          found_o,
   output logic [IW-1:0] idx_o
);
   always_comb begin
      found_o = |vec_i;
      idx_o   = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec_i[i]) idx_o = IW'(i);
      end
   end
endmodule

// File: rtl/tvs_rr_scan.sv
// Rotating priority search: first unlocked slot after the pointer,
// wrapping, with the pointer's own slot excluded.
module tvs_rr_scan #(
   parameter  int N  = 16,
   localparam int IW = $clog2(N)
) (
   input  logic [IW-1:0] ptr_i,
   input  logic [N-1:0]  locked_i,
   output logic          found_o,
   output logic [IW-1:0] idx_o
);
   localparam bit IS_POW2 = ((N & (N - 1)) == 0);

   logic [IW-1:0]  start;
   logic [N-1:0]   eligible;
   logic [2*N-1:0] doubled;
   logic [N-1:0]   rotated;
   logic [IW-1:0]  offset;
   logic [IW:0]    sum;

   assign start    = (ptr_i == IW'(N - 1)) ? '0 : ptr_i + 1'b1;
   assign eligible = ~locked_i & ~(N'(1) << ptr_i);
   assign doubled  = {eligible, eligible} >> start;
   assign rotated  = doubled[N-1:0];

   tvs_lowest_set #(.W(N)) u_enc (
      .vec_i   (rotated),
      .found_o (found_o),
      .idx_o   (offset)
   );

   assign sum = {1'b0, start} + {1'b0, offset};

   generate
      if (IS_POW2) begin : g_wrap_free
         assign idx_o = sum[IW-1:0];
      end else begin : g_wrap_sub
         assign idx_o = (sum >= (IW+1)'(N)) ? IW'(sum - (IW+1)'(N)) : sum[IW-1:0];
      end
   endgenerate
endmodule

// File: rtl/tvs_ptr_reg.sv
// Last-replaced pointer register.
module tvs_ptr_reg #(
   parameter  int N  = 16,
   localparam int IW = $clog2(N)
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          upd_i,
   input  logic [IW-1:0] nxt_i,
   output logic [IW-1:0] ptr_o
);
   always_ff @(posedge clk_i) begin
      if (rst_i)      ptr_o <= IW'(N - 1);
      else if (upd_i) ptr_o <= nxt_i;
   end
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel
   import tvs_pkg::*;
#(
   parameter  int N_SLOTS = 16,
   localparam int IDX_W   = $clog2(N_SLOTS)
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               insert_i,
   input  logic [N_SLOTS-1:0] slot_valid_i,
   input  logic [N_SLOTS-1:0] slot_locked_i,
   input  logic               force_en_i,
   input  logic [IDX_W-1:0]   force_idx_i,
   output logic [IDX_W-1:0]   victim_idx_o,
   output logic [IDX_W-1:0]   last_ptr_o
);
   generate
      if (N_SLOTS < 2) begin : g_bad_size
         $error("tlb_victim_sel: N_SLOTS must be at least 2");
      end
   endgenerate

   logic             free_found, scan_found, ptr_upd;
   logic [IDX_W-1:0] free_idx, scan_idx;
   pick_src_e        src;

   tvs_lowest_set #(.W(N_SLOTS)) u_free (
      .vec_i   (~slot_valid_i),
      .found_o (free_found),
      .idx_o   (free_idx)
   );

   tvs_rr_scan #(.N(N_SLOTS)) u_scan (
      .ptr_i    (last_ptr_o),
      .locked_i (slot_locked_i),
      .found_o  (scan_found),
      .idx_o    (scan_idx)
   );

   always_comb begin
      if (force_en_i) begin
         src          = PICK_FORCE;
         victim_idx_o = force_idx_i;
      end else if (free_found) begin
         src          = PICK_FREE;
         victim_idx_o = free_idx;
      end else if (scan_found) begin
         src          = PICK_SCAN;
         victim_idx_o = scan_idx;
      end else begin
         src          = PICK_FALLBACK;
         victim_idx_o = IDX_W'(N_SLOTS - 1);
      end
   end

   assign ptr_upd = insert_i && (src == PICK_SCAN);

   tvs_ptr_reg #(.N(N_SLOTS)) u_ptr (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .upd_i (ptr_upd),
      .nxt_i (victim_idx_o),
      .ptr_o (last_ptr_o)
   );
endmodule

// File: rtl/tlb_victim_sel_chk.sv
module tlb_victim_sel_chk #(
   parameter  int N_SLOTS = 16,
   localparam int IDX_W   = $clog2(N_SLOTS)
) (
   input logic               clk_i,
   input logic               rst_i,
   input logic               insert_i,
   input logic [N_SLOTS-1:0] slot_valid_i,
   input logic [N_SLOTS-1:0] slot_locked_i,
   input logic               force_en_i,
   input logic [IDX_W-1:0]   force_idx_i,
   input logic [IDX_W-1:0]   victim_idx_o,
   input logic [IDX_W-1:0]   last_ptr_o
);
   logic             any_free, all_locked;
   logic [N_SLOTS-1:0] below_victim;
   assign any_free     = !(&slot_valid_i);
   assign all_locked   = &slot_locked_i;
   assign below_victim = (N_SLOTS'(1) << victim_idx_o) - N_SLOTS'(1);

   a_r1_force_idx: assert property (@(posedge clk_i) disable iff (rst_i)
      force_en_i |-> victim_idx_o == force_idx_i);
   a_r1_force_ptr_hold: assert property (@(posedge clk_i) disable iff (rst_i)
      insert_i && force_en_i |=> $stable(last_ptr_o));
   a_r2_free_taken: assert property (@(posedge clk_i) disable iff (rst_i)
      !force_en_i && any_free |-> !slot_valid_i[victim_idx_o]);
   a_r3_lowest_free: assert property (@(posedge clk_i) disable iff (rst_i)
      !force_en_i && any_free |-> ((~slot_valid_i) & below_victim) == '0);
   a_r5_skip_locked: assert property (@(posedge clk_i) disable iff (rst_i)
      !force_en_i && !any_free && victim_idx_o != IDX_W'(N_SLOTS - 1)
      |-> !slot_locked_i[victim_idx_o]);
   a_r7_all_locked_top: assert property (@(posedge clk_i) disable iff (rst_i)
      !force_en_i && !any_free && all_locked |-> victim_idx_o == IDX_W'(N_SLOTS - 1));
   a_r7_fallback_hold: assert property (@(posedge clk_i) disable iff (rst_i)
      insert_i && !force_en_i && !any_free && all_locked |=> $stable(last_ptr_o));
   a_r8_ptr_follow: assert property (@(posedge clk_i) disable iff (rst_i)
      insert_i && !force_en_i && !any_free && !slot_locked_i[victim_idx_o]
      && victim_idx_o != last_ptr_o |=> last_ptr_o == $past(victim_idx_o));
   a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (rst_i)
      !insert_i |=> $stable(last_ptr_o));
   a_r8_free_hold: assert property (@(posedge clk_i) disable iff (rst_i)
      insert_i && any_free |=> $stable(last_ptr_o));
   a_r9_reset_ptr: assert property (@(posedge clk_i)
      rst_i |=> last_ptr_o == IDX_W'(N_SLOTS - 1));
endmodule

bind tlb_victim_sel tlb_victim_sel_chk #(.N_SLOTS(N_SLOTS)) u_chk (
   .clk_i         (clk_i),
   .rst_i         (rst_i),
   .insert_i      (insert_i),
   .slot_valid_i  (slot_valid_i),
   .slot_locked_i (slot_locked_i),
   .force_en_i    (force_en_i),
   .force_idx_i   (force_idx_i),
   .victim_idx_o  (victim_idx_o),
   .last_ptr_o    (last_ptr_o)
);

// File: tb/tb_tlb_victim_sel.sv
module tb_tlb_victim_sel;
   localparam int N  = 16;
   localparam int IW = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          insert = 1'b0;
   logic          fe = 1'b0;
   logic [IW-1:0] fi = '0;
   logic [N-1:0]  valid = '0;
   logic [N-1:0]  locked = '0;
   logic [IW-1:0] victim, ptr;

   int errors = 0;
   int checks = 0;
   int m_ptr  = N - 1;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   tlb_victim_sel #(.N_SLOTS(N)) dut (
      .clk_i(clk), .rst_i(rst), .insert_i(insert),
      .slot_valid_i(valid), .slot_locked_i(locked),
      .force_en_i(fe), .force_idx_i(fi),
      .victim_idx_o(victim), .last_ptr_o(ptr)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   // Behavioural reference: kind 0 forced, 1 free, 2 search hit, 3 fallback.
   function automatic int model(input logic [N-1:0] v, input logic [N-1:0] l,
                                input bit f, input int fidx, input int p,
                                output int kind);
      int x;
      if (f) begin kind = 0; return fidx; end
      for (int i = 0; i < N; i++) if (!v[i]) begin kind = 1; return i; end
      x = p;
      forever begin
         x = x + 1;
         if (x == N) x = 0;
         if (x == p) begin kind = 3; return N - 1; end
         if (!l[x]) begin kind = 2; return x; end
      end
   endfunction

   // Called at a falling edge; ends at the next falling edge.
   task automatic step(input logic [N-1:0] v, input logic [N-1:0] l, input bit ins,
                       input bit f, input int fidx, input int want);
      int kind, exp;
      string tag;
      valid = v; locked = l; insert = ins; fe = f; fi = IW'(fidx);
      #1;
      exp = model(v, l, f, fidx, m_ptr, kind);
      case (kind)
         0: tag = "R1";
         1: tag = "R2";
         2: tag = "R5";
         default: tag = "R7";
      endcase
      chk(tag, int'(victim), exp);
      if (want >= 0) chk(tag, int'(victim), want);
      chk("R8", int'(ptr), m_ptr);
      @(posedge clk);
      if (ins && kind == 2) m_ptr = exp;
      @(negedge clk);
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [N-1:0] ones;
      ones = '1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R9", int'(ptr), N - 1);             // R9 reset value
      rst = 1'b0;
      m_ptr = N - 1;

      // R10: output follows inputs within the cycle, no clock edge.
      fe = 1'b1; fi = 4'd9; #1;
      chk("R10", int'(victim), 9);
      fi = 4'd3; #1;
      chk("R10", int'(victim), 3);
      fe = 1'b0;
      @(negedge clk);

      step('0, '0, 1, 0, 0, 0);                                   // R3 all empty
      step(ones & ~(N'(1) << 5) & ~(N'(1) << 9), '0, 1, 0, 0, 5); // R3 lowest free
      step(ones & ~(N'(1) << 12), ones, 1, 0, 0, 12);             // R2 free beats locks
      step(ones, '0, 1, 1, 7, 7);                                 // R1 forced, ptr holds
      step(ones, '0, 1, 0, 0, 0);                                 // R4 first search at 0
      step(ones, '0, 1, 0, 0, 1);                                 // R4 next slot
      step(ones, (N'(1) << 2) | (N'(1) << 3), 1, 0, 0, 4);        // R5 skip 2,3
      step(ones, ones, 1, 0, 0, N - 1);                           // R7 all locked
      step(ones, ones & ~(N'(1) << 4), 1, 0, 0, N - 1);           // R6 only ptr slot free
      step(ones, '0, 0, 0, 0, 5);                                 // R8 no insert
      step(ones, ones & ~(N'(1) << 14), 1, 0, 0, 14);             // R4 far slot
      step(ones, N'(1) << 15, 1, 0, 0, 0);                        // R4 wrap past top
      chk("R8", int'(ptr), 0);

      for (int c = 0; c < 600; c++) begin
         logic [N-1:0] v, l;
         bit f;
         v = ($urandom % 4 == 0) ? (N'($urandom) | N'($urandom)) : ones;
         l = ($urandom % 3 == 0) ? ~(N'(1) << ($urandom % N)) : (N'($urandom) & N'($urandom));
         f = ($urandom % 8 == 0);
         step(v, l, ($urandom % 4 != 0), f, int'($urandom % N), -1);
      end

      // R9 reset in mid-run
      rst = 1'b1; @(posedge clk); @(negedge clk);
      chk("R9", int'(ptr), N - 1);
      rst = 1'b0; m_ptr = N - 1;
      step(ones, '0, 1, 0, 0, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule